// File: doc/BRIEF.md
# Sift-Out Redundancy Unit

The unit receives the results of several redundant channels that compute the same value and turns them into a single trusted result. It compares every channel with every other channel on each cycle. A channel that differs from most of its peers is taken out of service for good. The active set then shrinks over time, one or more channels at a time, but it never drops below two members. This lets a group of N channels survive up to N-2 channel failures that occur one after another.

The block has three parts. A pairwise equality matrix covers all channels. A detector holds the active-channel mask in registers and decides on each clock edge which channels to drop. A collector builds the output from the active channels that still have at least one active partner with the same value. If the remaining channels can no longer be sorted into good and bad, the mask stays as it is and a sticky unrecoverable-error flag is raised.

Top module: `sift_out_unit`

## Requirements
- R1: While `rst` is high, at every rising clock edge all NCH bits of `active` become 1 and `fatal` becomes 0.
- R2: When all active channels carry the same value, `out_data` equals that value in the same cycle and `active` does not change at the next edge.
- R3: An active channel is dropped at the next rising edge when it differs from more than half of the other active channels, and at least two channels remain after the drop. Bit i of `active` corresponds to channel i, which is `ch_data[i*W +: W]`.
- R4: Once a bit of `active` is cleared, it stays 0 until reset, even if the channel agrees again.
- R5: Only active channels take part in comparisons. The value of an inactive channel affects neither the drop decision nor `out_data`.
- R6: `out_data` is the bitwise OR of the values of all active channels that equal at least one other active channel. It is combinational from `ch_data` and the registered mask.
- R7: When exactly two channels are active and they differ, neither is dropped, `out_data` is 0 and `fatal` is set at the next edge.
- R8: If dropping all channels that are judged faulty would leave fewer than two active, nothing is dropped and `fatal` is set at the next edge (for example, three active channels that all differ).
- R9: `fatal` stays set until reset.
- R10: Several channels that are each in the minority in the same cycle are all dropped at the same edge.
- R11: Failures that occur in successive cycles are tolerated down to two channels, which is NCH-2 failures in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ch_data | input | NCH*W | Channel values, channel i in bits [i*W +: W] |
| out_data | output | W | Collected result |
| active | output | NCH | Registered mask of channels still in service |
| fatal | output | 1 | Sticky unrecoverable-disagreement flag |

## Verification
Some properties are checked on every cycle. A cleared mask bit never returns, at least two channels always stay active, and the error flag never drops outside reset. The output never carries a bit that no active channel drives. A newly raised error flag never comes with a mask change, and a mask change never happens while the flag is rising. Other behaviour depends on particular value patterns, and only the bench scenarios can show it. This covers which channel is judged in the minority, the exact collected value, the simultaneous removal of two minority channels, the refusal to drop when all three channels differ, and the exclusion of a dead channel's value.

// File: rtl/sift_pkg.sv
package sift_pkg;

    // Decision taken by the detector at each clock edge
    typedef enum logic [1:0] {
        SIFT_HOLD  = 2'd0,  // no active channel judged faulty
        SIFT_DROP  = 2'd1,  // faulty channels removed, two or more remain
        SIFT_STUCK = 2'd2   // removal would leave fewer than two: flag instead
    } sift_act_e;

    localparam int unsigned SIFT_MIN_LEFT = 2;

    // A channel is in the minority when its disagreements exceed half its peers
    function automatic logic in_minority(input int unsigned disagree_cnt,
                                         input int unsigned peer_cnt);
        return (2 * disagree_cnt) > peer_cnt;
    endfunction

endpackage

// File: rtl/sift_cmp_matrix.sv
module sift_cmp_matrix #(
    parameter int unsigned NCH = 5,
    parameter int unsigned W   = 8
) (
    input  logic [NCH*W-1:0]   ch_data,
    output logic [NCH*NCH-1:0] agree     // bit i*NCH+j: channel i equals channel j
);
    for (genvar i = 0; i < NCH; i++) begin : g_row
        for (genvar j = 0; j < NCH; j++) begin : g_col
            if (i == j) begin : g_self
                assign agree[i*NCH+j] = 1'b1;
            end else begin : g_pair
                assign agree[i*NCH+j] = (ch_data[i*W +: W] == ch_data[j*W +: W]);
            end
        end
    end
endmodule

// File: rtl/sift_detector.sv
module sift_detector
    import sift_pkg::*;
#(
    parameter int unsigned NCH = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NCH*NCH-1:0] agree,
    output logic [NCH-1:0]     active,
    output logic               fatal
);
    logic [NCH-1:0] faulty;
    logic [NCH-1:0] keep;
    sift_act_e      action;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            logic [NCH-1:0] peers;
            logic [NCH-1:0] differ;
            peers     = active;
            peers[i]  = 1'b0;
            differ    = peers & ~agree[i*NCH +: NCH];
            faulty[i] = active[i] &&
                        in_minority($countones(differ), $countones(peers));
        end
        keep = active & ~faulty;
        if (faulty == '0)
            action = SIFT_HOLD;
        else if ($countones(keep) >= SIFT_MIN_LEFT)
            action = SIFT_DROP;
        else
            action = SIFT_STUCK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '1;
            fatal  <= 1'b0;
        end else begin
            unique case (action)
                SIFT_DROP:  active <= keep;
                SIFT_STUCK: fatal  <= 1'b1;
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/sift_collector.sv
module sift_collector #(
    parameter int unsigned NCH = 5,
    parameter int unsigned W   = 8
) (
    input  logic [NCH*W-1:0]   ch_data,
    input  logic [NCH*NCH-1:0] agree,
    input  logic [NCH-1:0]     active,
    output logic [W-1:0]       out_data
);
    logic [NCH-1:0] backed;

    always_comb begin
        out_data = '0;
        for (int i = 0; i < NCH; i++) begin
            logic [NCH-1:0] partners;
            partners    = active & agree[i*NCH +: NCH];
            partners[i] = 1'b0;
            backed[i]   = active[i] && (partners != '0);
            if (backed[i])
                out_data = out_data | ch_data[i*W +: W];
        end
    end
endmodule

// File: rtl/sift_out_unit.sv
module sift_out_unit #(
    parameter int unsigned NCH = 5,
    parameter int unsigned W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH*W-1:0] ch_data,
    output logic [W-1:0]     out_data,
    output logic [NCH-1:0]   active,
    output logic             fatal
);
    localparam int unsigned PAIRS = NCH * NCH;

    logic [PAIRS-1:0] agree;

    sift_cmp_matrix #(.NCH(NCH), .W(W)) u_cmp (
        .ch_data (ch_data),
        .agree   (agree)
    );

    sift_detector #(.NCH(NCH)) u_det (
        .clk    (clk),
        .rst    (rst),
        .agree  (agree),
        .active (active),
        .fatal  (fatal)
    );

    sift_collector #(.NCH(NCH), .W(W)) u_col (
        .ch_data  (ch_data),
        .agree    (agree),
        .active   (active),
        .out_data (out_data)
    );
endmodule

// File: rtl/sift_out_unit_chk.sv
module sift_out_unit_chk #(
    parameter int unsigned NCH = 5,
    parameter int unsigned W   = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [NCH*W-1:0] ch_data,
    input logic [W-1:0]     out_data,
    input logic [NCH-1:0]   active,
    input logic             fatal
);
    logic [W-1:0] any_active_bits;

    always_comb begin
        any_active_bits = '0;
        for (int i = 0; i < NCH; i++)
            if (active[i]) any_active_bits = any_active_bits | ch_data[i*W +: W];
    end

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (active == '1 && !fatal));

    p_never_regain_r4: assert property (@(posedge clk) disable iff (rst)
        (active & ~$past(active)) == '0);

    p_two_left_r11: assert property (@(posedge clk) disable iff (rst)
        $countones(active) >= 2);

    p_fatal_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        $past(fatal) |-> fatal);

    p_out_from_active_r6: assert property (@(posedge clk) disable iff (rst)
        (out_data & ~any_active_bits) == '0);

    p_no_drop_when_stuck_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(fatal) |-> $stable(active));
endmodule

bind sift_out_unit sift_out_unit_chk #(.NCH(NCH), .W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ch_data  (ch_data),
    .out_data (out_data),
    .active   (active),
    .fatal    (fatal)
);

// File: tb/sift_out_unit_test.sv
module sift_out_unit_test;
    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [39:0]  d5  = '0;
    logic [23:0]  d3  = '0;
    logic [W-1:0] o5, o3;
    logic [4:0]   a5;
    logic [2:0]   a3;
    logic         f5, f3;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;  // 125 MHz

    sift_out_unit #(.NCH(5), .W(W)) uut (
        .clk(clk), .rst(rst), .ch_data(d5), .out_data(o5), .active(a5), .fatal(f5));

    sift_out_unit #(.NCH(3), .W(W)) uut3 (
        .clk(clk), .rst(rst), .ch_data(d3), .out_data(o3), .active(a3), .fatal(f3));

    typedef struct packed {
        logic [39:0] data;   // {ch4,ch3,ch2,ch1,ch0}
        logic [7:0]  out;    // expected out_data in the same cycle
        logic [4:0]  act;    // expected mask after the edge
        logic        fat;    // expected flag after the edge
    } vec_t;

    // Sequential failures on five channels, ending with two that disagree
    localparam vec_t TBL [8] = '{
        '{40'h3C3C3C3C3C, 8'h3C, 5'b11111, 1'b0},  // R2 all agree
        '{40'hA53C3C3C3C, 8'h3C, 5'b01111, 1'b0},  // R3 ch4 minority
        '{40'h3C3C3C3C3C, 8'h3C, 5'b01111, 1'b0},  // R4 ch4 stays out
        '{40'hFF22111111, 8'h11, 5'b00111, 1'b0},  // R5 ch3 dropped, dead ch4 ignored
        '{40'h7777084040, 8'h40, 5'b00011, 1'b0},  // R11 third failure
        '{40'h0000004040, 8'h40, 5'b00011, 1'b0},  // R6 two left agree
        '{40'h0000004140, 8'h00, 5'b00011, 1'b1},  // R7 two left disagree
        '{40'h0000004040, 8'h40, 5'b00011, 1'b1}   // R9 flag held
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1 reset mask N5", 64'(a5), 64'h1F);
        check("R1 reset flag N5", 64'(f5), 64'h0);
        check("R1 reset mask N3", 64'(a3), 64'h7);

        for (int k = 0; k < 8; k++) begin
            d5 = TBL[k].data;
            #2;
            check($sformatf("R6 row %0d out (R2 R3 R5 R7)", k), 64'(o5), 64'(TBL[k].out));
            @(negedge clk);
            check($sformatf("R4 row %0d mask (R3 R11)", k), 64'(a5), 64'(TBL[k].act));
            check($sformatf("R9 row %0d flag (R7)", k), 64'(f5), 64'(TBL[k].fat));
        end

        // R1: reset clears the flag and restores all channels
        do_reset();
        check("R1 mask after re-reset", 64'(a5), 64'h1F);
        check("R1 flag after re-reset", 64'(f5), 64'h0);

        // R10: two minority channels dropped at the same edge
        d5 = 40'hE1C35A5A5A;
        #2;
        check("R10 out excludes both minorities", 64'(o5), 64'h5A);
        @(negedge clk);
        check("R10 both dropped", 64'(a5), 64'h07);
        check("R10 no flag", 64'(f5), 64'h0);

        // R8: three channels all different, no drop possible
        d3 = 24'h040201;
        #2;
        check("R8 out zero", 64'(o3), 64'h0);
        @(negedge clk);
        check("R8 mask kept", 64'(a3), 64'h7);
        check("R8 flag set", 64'(f3), 64'h1);

        // R3 on three channels, then R7 with the last two
        do_reset();
        d3 = 24'h0F0909;
        #2;
        check("R3 N3 out", 64'(o3), 64'h09);
        @(negedge clk);
        check("R3 N3 ch2 dropped", 64'(a3), 64'h3);
        check("R11 N3 no flag", 64'(f3), 64'h0);
        d3 = 24'h0F0A09;
        #2;
        check("R7 N3 out zero", 64'(o3), 64'h0);
        @(negedge clk);
        check("R7 N3 mask kept", 64'(a3), 64'h3);
        check("R7 N3 flag set", 64'(f3), 64'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule